// File: doc/BRIEF.md
# Hypervisor Register Access Controller

This block owns the 64-bit base register of the second-stage address translation tables and decides, for every system-register access request aimed at it, what the access does. A request carries the five instruction encoding fields, a read/write flag and a write value. It also carries the requester's privilege level (0 to 3), a flag saying that the hypervisor level is active, and two nested-virtualization controls. The first, `nest_en`, makes lower-level accesses belong to the hypervisor. The second, `nest_mem`, turns those accesses into memory accesses.

One cycle after a request is sampled, the block gives exactly one response. A direct response reads or writes the register. A redirect response sends the access to a fixed memory slot. A trap response raises an exception to the hypervisor with a fixed syndrome class. An undefined response reports an undefined instruction. A foreign response means the encoding does not select this register. The block does not perform the memory access and does not enter the exception. The top eight bits of the register hold the upper byte of the guest identifier. They read as zero unless the wide identifier is both built in and switched on.

The control is a two-state machine. `ST_IDLE` moves to `ST_REPLY` when a request is present. `ST_REPLY` stays in `ST_REPLY` when another request arrives back to back. `ST_REPLY` returns to `ST_IDLE` when no request arrives. Responses are asserted only in `ST_REPLY`.

Top module: `hyp_reg_access_ctl`

## Requirements
- R1: A request whose fields are not op0=2'b11, op1=3'b100, CRn=4'b0010, CRm=4'b0001, op2=3'b000 gets the foreign response whatever its level, and it leaves the register unchanged. Reads and writes use the same encoding.
- R2: A matching request at level 0 gets the undefined response.
- R3: A matching request at level 1 gets the redirect response when `el2_enabled`, `nest_en` and `nest_mem` are all 1. The response carries offset 12'h020 and the write flag. For a write it also carries the write value; for a read the memory data output is zero.
- R4: A matching request at level 1 gets the trap response with class 6'h18 when `el2_enabled` and `nest_en` are 1 and `nest_mem` is 0.
- R5: Any other matching request at level 1 gets the undefined response.
- R6: A matching request at level 2 or 3 gets the direct response. A read returns the register value. A write stores all 64 bits, and `rsp_rdata` is zero for a write.
- R7: Bits [63:56] of the data returned by a direct read are zero unless `HAS_WIDE_ID` is 1 and `guest_id_wide` is 1. The stored bits are kept, so they show again once the wide identifier is switched on.
- R8: Exactly one response output is high, for one cycle, in the cycle after each sampled request. No response output is high in a cycle that does not follow a request.
- R9: A direct write takes effect at the clock edge that samples it, so a read sampled at the very next edge returns the new value.
- R10: During reset and right after it, all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write value |
| cur_el | input | 2 | Requester privilege level |
| el2_enabled | input | 1 | Hypervisor level active |
| nest_en | input | 1 | Nested control: hypervisor owns lower-level accesses |
| nest_mem | input | 1 | Nested control: turn those accesses into memory accesses |
| guest_id_wide | input | 1 | Wide guest identifier switched on |
| rsp_direct | output | 1 | Direct register access done |
| rsp_rdata | output | 64 | Register read data (zero for writes) |
| rsp_redirect | output | 1 | Access redirected to memory |
| rsp_mem_offset | output | 12 | Memory slot offset of the redirect |
| rsp_mem_write | output | 1 | The redirected access is a write |
| rsp_mem_wdata | output | 64 | Value to store for a redirected write |
| rsp_trap | output | 1 | Trap to the hypervisor |
| rsp_trap_class | output | 6 | Syndrome class of the trap |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_foreign | output | 1 | Encoding does not select this register |

## Verification
Some behaviours are checked by the assertions on every cycle:
- at most one response kind is high at a time;
- every response follows a sampled request;
- for each kind of matching request, the routing matches its level and nested-control combination;
- the foreign response follows every non-matching request;
- the upper identifier byte stays masked.

Other behaviours can only be shown by the bench's scenarios, because they depend on the stored data over time:
- a write followed at once by a read returns the new value;
- a foreign or redirected write leaves the register unchanged;
- the masked bits come back once the wide identifier is switched on.

// File: rtl/hrac_pkg.sv
package hrac_pkg;

    // Encoding that selects the translation base register
    localparam logic [1:0] SEL_OP0 = 2'b11;
    localparam logic [2:0] SEL_OP1 = 3'b100;
    localparam logic [3:0] SEL_CRN = 4'b0010;
    localparam logic [3:0] SEL_CRM = 4'b0001;
    localparam logic [2:0] SEL_OP2 = 3'b000;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_DIRECT  = 3'd1,
        K_REDIR   = 3'd2,
        K_TRAP    = 3'd3,
        K_UNDEF   = 3'd4,
        K_FOREIGN = 3'd5
    } kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } st_e;

endpackage

// File: rtl/hrac_match.sv
module hrac_match (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    import hrac_pkg::*;

    logic [4:0] field_ok;

    always_comb begin
        field_ok[0] = (op0 == SEL_OP0);
        field_ok[1] = (op1 == SEL_OP1);
        field_ok[2] = (crn == SEL_CRN);
        field_ok[3] = (crm == SEL_CRM);
        field_ok[4] = (op2 == SEL_OP2);
        hit         = &field_ok;
    end
endmodule

// File: rtl/hrac_route.sv
module hrac_route (
    input  logic               hit,
    input  logic [1:0]         el,
    input  logic               el2_on,
    input  logic               nest_en,
    input  logic               nest_mem,
    output hrac_pkg::kind_e    kind
);
    import hrac_pkg::*;

    always_comb begin
        kind = K_UNDEF;
        if (!hit) begin
            kind = K_FOREIGN;
        end else begin
            unique case (el)
                2'd0: kind = K_UNDEF;
                2'd1: begin
                    if (el2_on && nest_en && nest_mem)
                        kind = K_REDIR;
                    else if (el2_on && nest_en)
                        kind = K_TRAP;
                    else
                        kind = K_UNDEF;
                end
                2'd2,
                2'd3: kind = K_DIRECT;
                default: kind = K_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/hrac_base_store.sv
module hrac_base_store #(
    parameter int DATA_W      = 64,
    parameter int ID_HI_W     = 8,
    parameter bit HAS_WIDE_ID = 1'b1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              wide_on,
    output logic [DATA_W-1:0] rd_value
);
    localparam int LO_W = DATA_W - ID_HI_W;

    logic [DATA_W-1:0] base_q;
    logic              show_hi;

    // Contents have no defined reset value; software writes before use.
    always_ff @(posedge clk) begin
        if (wr_en)
            base_q <= wr_value;
    end

    assign show_hi  = HAS_WIDE_ID && wide_on;
    assign rd_value = {show_hi ? base_q[DATA_W-1:LO_W] : {ID_HI_W{1'b0}},
                       base_q[LO_W-1:0]};
endmodule

// File: rtl/hyp_reg_access_ctl.sv
module hyp_reg_access_ctl #(
    parameter int              DATA_W      = 64,
    parameter int              ID_HI_W     = 8,
    parameter bit              HAS_WIDE_ID = 1'b1,
    parameter int              OFFSET_W    = 12,
    parameter int              CLASS_W     = 6,
    parameter logic [11:0]     MEM_SLOT    = 12'h020,
    parameter logic [5:0]      TRAP_CODE   = 6'h18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_op0,
    input  logic [2:0]          req_op1,
    input  logic [3:0]          req_crn,
    input  logic [3:0]          req_crm,
    input  logic [2:0]          req_op2,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [1:0]          cur_el,
    input  logic                el2_enabled,
    input  logic                nest_en,
    input  logic                nest_mem,
    input  logic                guest_id_wide,
    output logic                rsp_direct,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_redirect,
    output logic [OFFSET_W-1:0] rsp_mem_offset,
    output logic                rsp_mem_write,
    output logic [DATA_W-1:0]   rsp_mem_wdata,
    output logic                rsp_trap,
    output logic [CLASS_W-1:0]  rsp_trap_class,
    output logic                rsp_undef,
    output logic                rsp_foreign
);
    import hrac_pkg::*;

    localparam logic [OFFSET_W-1:0] SLOT_OUT  = OFFSET_W'(MEM_SLOT);
    localparam logic [CLASS_W-1:0]  CLASS_OUT = CLASS_W'(TRAP_CODE);

    logic              hit;
    kind_e             kind_now;
    logic [DATA_W-1:0] cur_value;
    logic              store_we;

    st_e               state_q, state_d;
    kind_e             kind_q;
    logic              wr_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] mwdata_q;

    hrac_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (hit)
    );

    hrac_route u_route (
        .hit      (hit),
        .el       (cur_el),
        .el2_on   (el2_enabled),
        .nest_en  (nest_en),
        .nest_mem (nest_mem),
        .kind     (kind_now)
    );

    assign store_we = req_valid && req_write && (kind_now == K_DIRECT);

    hrac_base_store #(
        .DATA_W      (DATA_W),
        .ID_HI_W     (ID_HI_W),
        .HAS_WIDE_ID (HAS_WIDE_ID)
    ) u_store (
        .clk      (clk),
        .wr_en    (store_we),
        .wr_value (req_wdata),
        .wide_on  (guest_id_wide),
        .rd_value (cur_value)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= K_NONE;
            wr_q     <= 1'b0;
            rdata_q  <= '0;
            mwdata_q <= '0;
        end else if (req_valid) begin
            kind_q   <= kind_now;
            wr_q     <= req_write;
            rdata_q  <= (kind_now == K_DIRECT && !req_write) ? cur_value : '0;
            mwdata_q <= (kind_now == K_REDIR && req_write) ? req_wdata : '0;
        end else begin
            kind_q   <= K_NONE;
            wr_q     <= 1'b0;
            rdata_q  <= '0;
            mwdata_q <= '0;
        end
    end

    // Output decode, active only while replying
    always_comb begin
        rsp_direct     = 1'b0;
        rsp_redirect   = 1'b0;
        rsp_trap       = 1'b0;
        rsp_undef      = 1'b0;
        rsp_foreign    = 1'b0;
        rsp_rdata      = '0;
        rsp_mem_offset = '0;
        rsp_mem_write  = 1'b0;
        rsp_mem_wdata  = '0;
        rsp_trap_class = '0;
        if (state_q == ST_REPLY) begin
            unique case (kind_q)
                K_DIRECT: begin
                    rsp_direct = 1'b1;
                    rsp_rdata  = rdata_q;
                end
                K_REDIR: begin
                    rsp_redirect   = 1'b1;
                    rsp_mem_offset = SLOT_OUT;
                    rsp_mem_write  = wr_q;
                    rsp_mem_wdata  = mwdata_q;
                end
                K_TRAP: begin
                    rsp_trap       = 1'b1;
                    rsp_trap_class = CLASS_OUT;
                end
                K_UNDEF:   rsp_undef   = 1'b1;
                K_FOREIGN: rsp_foreign = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hrac_checker.sv
module hrac_checker #(
    parameter int DATA_W      = 64,
    parameter int ID_HI_W     = 8,
    parameter bit HAS_WIDE_ID = 1'b1,
    parameter int OFFSET_W    = 12,
    parameter int CLASS_W     = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_op0,
    input logic [2:0]          req_op1,
    input logic [3:0]          req_crn,
    input logic [3:0]          req_crm,
    input logic [2:0]          req_op2,
    input logic [1:0]          cur_el,
    input logic                el2_enabled,
    input logic                nest_en,
    input logic                nest_mem,
    input logic                guest_id_wide,
    input logic                rsp_direct,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                rsp_redirect,
    input logic [OFFSET_W-1:0] rsp_mem_offset,
    input logic                rsp_trap,
    input logic [CLASS_W-1:0]  rsp_trap_class,
    input logic                rsp_undef,
    input logic                rsp_foreign
);
    logic sel;
    logic any_rsp;

    assign sel = (req_op0 == 2'b11) && (req_op1 == 3'b100) && (req_crn == 4'b0010)
              && (req_crm == 4'b0001) && (req_op2 == 3'b000);
    assign any_rsp = rsp_direct | rsp_redirect | rsp_trap | rsp_undef | rsp_foreign;

    assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_direct, rsp_redirect, rsp_trap, rsp_undef, rsp_foreign}));

    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> any_rsp);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !any_rsp);

    assert_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel) |=> rsp_foreign);

    assert_level0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && cur_el == 2'd0) |=> rsp_undef);

    assert_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && cur_el == 2'd1 && el2_enabled && nest_en && nest_mem)
        |=> (rsp_redirect && rsp_mem_offset == OFFSET_W'(12'h020)));

    assert_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && cur_el == 2'd1 && el2_enabled && nest_en && !nest_mem)
        |=> (rsp_trap && rsp_trap_class == CLASS_W'(6'h18)));

    assert_level1_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && cur_el == 2'd1 && !(el2_enabled && nest_en)) |=> rsp_undef);

    assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && cur_el[1]) |=> rsp_direct);

    assert_id_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(HAS_WIDE_ID && guest_id_wide))
        |=> (rsp_rdata[DATA_W-1:DATA_W-ID_HI_W] == '0));
endmodule

bind hyp_reg_access_ctl hrac_checker #(
    .DATA_W      (DATA_W),
    .ID_HI_W     (ID_HI_W),
    .HAS_WIDE_ID (HAS_WIDE_ID),
    .OFFSET_W    (OFFSET_W),
    .CLASS_W     (CLASS_W)
) u_chk (.*);

// File: tb/sim_hyp_reg_access_ctl.sv
`timescale 1ns/1ps
module sim_hyp_reg_access_ctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [63:0] req_wdata;
    logic [1:0]  cur_el;
    logic        el2_enabled, nest_en, nest_mem, guest_id_wide;
    logic        rsp_direct, rsp_redirect, rsp_mem_write, rsp_trap, rsp_undef, rsp_foreign;
    logic [63:0] rsp_rdata, rsp_mem_wdata;
    logic [11:0] rsp_mem_offset;
    logic [5:0]  rsp_trap_class;

    int compared = 0;
    int mismatched = 0;
    logic [63:0] model;

    always #5 clk = ~clk;

    hyp_reg_access_ctl u0 (.*);

    // Expected kind: 1 direct, 2 redirect, 3 trap, 4 undef, 5 foreign
    function automatic int exp_kind(input logic hit, input logic [1:0] el,
                                    input logic e2, input logic ne, input logic nm);
        if (!hit) return 5;
        if (el == 2'd0) return 4;
        if (el == 2'd1) begin
            if (e2 && ne && nm) return 2;
            if (e2 && ne) return 3;
            return 4;
        end
        return 1;
    endfunction

    function automatic int got_kind();
        int k = 0;
        int n = 0;
        if (rsp_direct)   begin k = 1; n++; end
        if (rsp_redirect) begin k = 2; n++; end
        if (rsp_trap)     begin k = 3; n++; end
        if (rsp_undef)    begin k = 4; n++; end
        if (rsp_foreign)  begin k = 5; n++; end
        return (n > 1) ? 9 : k;
    endfunction

    function automatic string kind_tag(input int k);
        case (k)
            1: return "R6";
            2: return "R3";
            3: return "R4";
            4: return "R2/R5";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic hit, input logic [1:0] el,
                         input logic e2, input logic ne, input logic nm,
                         input logic [63:0] wd);
        int ek;
        logic [63:0] exp_rd;
        req_valid   = 1'b1;
        req_write   = wr;
        cur_el      = el;
        el2_enabled = e2;
        nest_en     = ne;
        nest_mem    = nm;
        req_wdata   = wd;
        if (hit) begin
            req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b0010;
            req_crm = 4'b0001; req_op2 = 3'b000;
        end else begin
            do begin
                req_op0 = 2'($urandom); req_op1 = 3'($urandom); req_crn = 4'($urandom);
                req_crm = 4'($urandom); req_op2 = 3'($urandom);
            end while (req_op0 == 2'b11 && req_op1 == 3'b100 && req_crn == 4'b0010 &&
                       req_crm == 4'b0001 && req_op2 == 3'b000);
        end
        ek = exp_kind(hit, el, e2, ne, nm);
        @(posedge clk);
        @(negedge clk);
        check({kind_tag(ek), " kind"}, 64'(got_kind()), 64'(ek));
        if (ek == 1) begin
            exp_rd = wr ? 64'd0 :
                     (guest_id_wide ? model : {8'h00, model[55:0]});
            check("R6/R7 rdata", rsp_rdata, exp_rd);
            if (wr) model = wd;
        end else if (ek == 2) begin
            check("R3 offset", 64'(rsp_mem_offset), 64'h020);
            check("R3 write flag", 64'(rsp_mem_write), 64'(wr));
            check("R3 wdata", rsp_mem_wdata, wr ? wd : 64'd0);
        end else if (ek == 3) begin
            check("R4 class", 64'(rsp_trap_class), 64'h18);
        end
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 idle no response", 64'(got_kind()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_op0 = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0;
        req_wdata = '0; cur_el = '0; el2_enabled = 0; nest_en = 0; nest_mem = 0;
        guest_id_wide = 1'b1;
        model = '0;
        repeat (3) @(negedge clk);
        check("R10 reset quiet", 64'(got_kind()), 64'd0);
        req_valid = 1'b1;
        @(negedge clk);
        check("R10 reset holds off request", 64'(got_kind()), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 64'(got_kind()), 64'd0);

        // R9: write then read back to back
        issue(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 64'hA5A5_0123_4567_89AB);
        issue(1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 64'd0);
        check("R9 readback", rsp_rdata, 64'hA5A5_0123_4567_89AB);
        go_idle();

        // R1: foreign write leaves register unchanged
        issue(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF);
        issue(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 64'd0);
        check("R1 register unchanged", rsp_rdata, 64'hA5A5_0123_4567_89AB);

        // R3 redirected write does not touch the register
        issue(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 64'h1111_2222_3333_4444);
        issue(1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 64'd0);
        issue(1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 64'd0);
        check("R3 register unchanged", rsp_rdata, 64'hA5A5_0123_4567_89AB);

        // R2, R4, R5 corners
        issue(1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 64'd0);
        issue(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 64'h5);
        issue(1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 64'd0);
        issue(1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 64'd0);
        go_idle();

        // R7: upper byte masked, stored bits kept
        guest_id_wide = 1'b0;
        issue(1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 64'hFF00_0000_0000_0077);
        issue(1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 64'd0);
        check("R7 masked", rsp_rdata, 64'h0000_0000_0000_0077);
        guest_id_wide = 1'b1;
        issue(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 64'd0);
        check("R7 restored", rsp_rdata, 64'hFF00_0000_0000_0077);
        go_idle();

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            guest_id_wide = ($urandom % 4) != 0;
            issue(1'($urandom), ($urandom % 4) != 0, 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom),
                  {$urandom, $urandom});
            if ($urandom % 8 == 0) go_idle();
        end
        go_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule